// File: doc/BRIEF.md
# Linked Descriptor Reload Engine

This engine sits beside one transfer channel. When the channel reports that its configured transfer is over, the engine looks at the channel's current next-descriptor pointer. If the pointer is zero, the chain is over and the engine pulses a channel-complete flag. If the pointer is non-zero, the engine reads a ten-word descriptor from memory at that address and writes each word into the matching channel configuration register. It then pulses a restart so the channel runs the new configuration.

A descriptor holds its own next pointer, so a chain can end, continue or loop back on itself. A looped chain keeps reloading for as long as the channel stays enabled and keeps reporting completion.

The engine also clears peripheral flags for the channel. After every served request it writes the channel's current mask data word to the channel's current mask address, unless that address is zero.

The channel register file is outside this block. The engine reads the current pointer, mask address and mask data from that register file and writes updated values back into it.

Descriptor word positions are fixed:

| Index | Content |
|-------|---------|
| 0 | transfer control |
| 1 | block count and length |
| 2 | source address |
| 3 | destination address |
| 4 | block repeat offsets |
| 5 | next-descriptor pointer |
| 6 | trigger and bus select |
| 7 | reserved |
| 8 | mask address |
| 9 | mask data |

Top module: `chain_loader`

## Requirements
- R1: A reload issues exactly ten word reads, one at a time, at the pointer plus 0, 4, 8 and so on up to 36. The address and strobe of each read are held until `mem_ack`.
- R2: Each fetched word is written on `reg_we`, with `reg_sel` equal to its index in the descriptor. The reserved word at index 7 is read but never written.
- R3: `restart` is high for exactly one cycle. That cycle is the one right after the cycle in which word 9 is written.
- R4: At transfer end with a zero pointer, `chain_end` pulses once and no memory access is made.
- R5: A non-zero pointer whose low two bits are not 00 sets `err_align`. No memory access is made and no restart follows.
- R6: A served request with a non-zero mask address causes one memory write of the mask data to that address. A zero mask address causes no write.
- R7: When a mask write and a reload are both pending, the mask write is issued first.
- R8: A read that returns `mem_err` sets `err_link`. The fetch stops at that read: later words are neither read nor written, and no restart follows.
- R9: A mask write that returns `mem_err` sets `err_mask` and leaves `err_link` alone.
- R10: A chain whose last descriptor points back to its first keeps reloading on every transfer end. A transfer end is ignored while `chan_en` is low.
- R11: After reset, every output is low.
- R12: The error flags stay set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| chan_en | input | 1 | channel enabled; a transfer end counts only while high |
| xfer_done | input | 1 | one-cycle pulse: configured transfer finished |
| req_served | input | 1 | one-cycle pulse: a request was served |
| cur_link | input | 32 | current next-descriptor pointer from the channel registers |
| cur_mask_addr | input | 32 | current mask address from the channel registers |
| cur_mask_data | input | 32 | current mask data from the channel registers |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | byte address |
| mem_wdata | output | 32 | write data |
| mem_ack | input | 1 | access completes in this cycle |
| mem_rdata | input | 32 | read data, valid with `mem_ack` |
| mem_err | input | 1 | access failed, valid with `mem_ack` |
| reg_we | output | 1 | channel register write strobe |
| reg_sel | output | 4 | index of the register written |
| reg_wdata | output | 32 | value written |
| restart | output | 1 | one-cycle pulse: restart the channel |
| chain_end | output | 1 | one-cycle pulse: channel-complete flag |
| err_link | output | 1 | sticky: descriptor read failed |
| err_mask | output | 1 | sticky: mask write failed |
| err_align | output | 1 | sticky: misaligned pointer |

## Verification
The properties are checked on every cycle:
- the reserved index never reaches the register port;
- `restart` always directly follows the write of word 9;
- a pending memory access keeps its address stable;
- descriptor reads are word aligned;
- the error flags never clear.

Only the bench's scenarios can show the rest. These are the exact read sequence and the data copied into the registers. They also cover a chain looping between two descriptors, mask writes issued or suppressed by the mask address, the mask write winning when both jobs are pending, and the end-of-chain, misaligned, read-error and write-error cases.

// File: rtl/chain_loader.sv
module chain_loader #(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int NWORDS   = 10,
  parameter int RSVD_IDX = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chan_en,
  input  logic                          xfer_done,
  input  logic                          req_served,
  input  logic [AW-1:0]                 cur_link,
  input  logic [AW-1:0]                 cur_mask_addr,
  input  logic [DW-1:0]                 cur_mask_data,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [AW-1:0]                 mem_addr,
  output logic [DW-1:0]                 mem_wdata,
  input  logic                          mem_ack,
  input  logic [DW-1:0]                 mem_rdata,
  input  logic                          mem_err,
  output logic                          reg_we,
  output logic [$clog2(NWORDS)-1:0]     reg_sel,
  output logic [DW-1:0]                 reg_wdata,
  output logic                          restart,
  output logic                          chain_end,
  output logic                          err_link,
  output logic                          err_mask,
  output logic                          err_align
);
  localparam int IW = $clog2(NWORDS);
  localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);
  localparam logic [IW-1:0] RSVD = IW'(RSVD_IDX);

  typedef enum logic [1:0] {S_IDLE, S_MASK, S_FETCH, S_KICK} state_t;
  state_t state;

  logic [AW-1:0] base, m_addr;
  logic [DW-1:0] m_data;
  logic [IW-1:0] w;
  logic          mask_pend, done_pend;

  assign mem_req   = (state == S_MASK) || (state == S_FETCH);
  assign mem_we    = (state == S_MASK);
  assign mem_addr  = (state == S_MASK) ? m_addr : base + {{(AW-IW-2){1'b0}}, w, 2'b00};
  assign mem_wdata = m_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      base      <= '0;
      m_addr    <= '0;
      m_data    <= '0;
      w         <= '0;
      mask_pend <= 1'b0;
      done_pend <= 1'b0;
      reg_we    <= 1'b0;
      reg_sel   <= '0;
      reg_wdata <= '0;
      restart   <= 1'b0;
      chain_end <= 1'b0;
      err_link  <= 1'b0;
      err_mask  <= 1'b0;
      err_align <= 1'b0;
    end else begin
      reg_we    <= 1'b0;
      restart   <= 1'b0;
      chain_end <= 1'b0;
      case (state)
        S_IDLE: begin
          if (mask_pend) begin
            mask_pend <= 1'b0;
            state     <= S_MASK;
          end else if (done_pend) begin
            done_pend <= 1'b0;
            if (cur_link == '0) begin
              chain_end <= 1'b1;
            end else if (cur_link[1:0] != 2'b00) begin
              err_align <= 1'b1;
            end else begin
              base  <= cur_link;
              w     <= '0;
              state <= S_FETCH;
            end
          end
        end
        S_MASK: begin
          if (mem_ack) begin
            if (mem_err) err_mask <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            if (mem_err) begin
              err_link <= 1'b1;
              state    <= S_IDLE;
            end else begin
              reg_we    <= (w != RSVD);
              reg_sel   <= w;
              reg_wdata <= mem_rdata;
              if (w == LAST) state <= S_KICK;
              else           w     <= w + 1'b1;
            end
          end
        end
        default: begin
          restart <= 1'b1;
          state   <= S_IDLE;
        end
      endcase
      if (req_served && cur_mask_addr != '0) begin
        mask_pend <= 1'b1;
        m_addr    <= cur_mask_addr;
        m_data    <= cur_mask_data;
      end
      if (xfer_done && chan_en) done_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/chain_loader_chk.sv
module chain_loader_chk #(
  parameter int AW   = 32,
  parameter int IW   = 4,
  parameter int RSVD = 7,
  parameter int LAST = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic          reg_we,
  input logic [IW-1:0] reg_sel,
  input logic          restart,
  input logic          err_link,
  input logic          err_mask,
  input logic          err_align
);
  a_r2_reserved_skipped: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> reg_sel != IW'(RSVD));

  a_r3_restart_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> $past(reg_we && reg_sel == IW'(LAST)));

  a_r3_last_then_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == IW'(LAST)) |=> restart);

  a_r1_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  a_r1_read_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> mem_addr[1:0] == 2'b00);

  a_r12_errors_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past({err_link, err_mask, err_align}) & ~{err_link, err_mask, err_align}) == 3'b000);
endmodule

bind chain_loader chain_loader_chk #(.AW(AW), .IW($clog2(NWORDS)), .RSVD(RSVD_IDX), .LAST(NWORDS-1))
  u_chk (.clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
         .mem_addr(mem_addr), .reg_we(reg_we), .reg_sel(reg_sel), .restart(restart),
         .err_link(err_link), .err_mask(err_mask), .err_align(err_align));

// File: tb/chain_loader_test.sv
module chain_loader_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b1, xfer_done = 1'b0, req_served = 1'b0;
  logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        reg_we, restart, chain_end, err_link, err_mask, err_align;
  logic [3:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] regs [10];
  logic [31:0] mem [128];

  always #(PERIOD/2) clk = ~clk;

  chain_loader uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .xfer_done(xfer_done), .req_served(req_served),
    .cur_link(regs[5]), .cur_mask_addr(regs[8]), .cur_mask_data(regs[9]),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .restart(restart),
    .chain_end(chain_end), .err_link(err_link), .err_mask(err_mask), .err_align(err_align));

  int vecs = 0, miss = 0;
  int got_restart = 0, exp_restart = 0, got_end = 0, exp_end = 0;
  logic prev_last = 1'b0;
  logic [31:0] err_rd = 32'hFFFF_FFFF, err_wr = 32'hFFFF_FFFF;
  logic [31:0] exp_link = '0, exp_maddr = '0, exp_mdata = '0;
  logic exp_elink = 1'b0, exp_emask = 1'b0, exp_ealign = 1'b0;
  logic        eq_we [$];
  logic [31:0] eq_addr [$], eq_data [$];
  logic [3:0]  er_sel [$];
  logic [31:0] er_data [$];

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick();
    logic nack;
    @(negedge clk);
    if (reg_we) begin
      if (er_sel.size() == 0) chk("R2 unexpected register write", {28'd0, reg_sel}, 32'hFFFF_FFFF);
      else begin
        chk("R2 register index", {28'd0, reg_sel}, {28'd0, er_sel.pop_front()});
        chk("R2 register data", reg_wdata, er_data.pop_front());
      end
      regs[reg_sel] = reg_wdata;
    end
    if (restart) begin
      got_restart++;
      chk("R3 restart follows word 9", {31'd0, prev_last}, 32'd1);
    end
    prev_last = reg_we && reg_sel == 4'd9;
    if (chain_end) got_end++;
    nack = mem_req && !mem_ack;
    if (nack) begin
      if (eq_we.size() == 0) chk("R1 unexpected memory access", mem_addr, 32'hFFFF_FFFF);
      else begin
        chk(mem_we ? "R6 access kind" : "R1 access kind", {31'd0, mem_we}, {31'd0, eq_we[0]});
        chk(mem_we ? "R6 write address" : "R1 read address", mem_addr, eq_addr.pop_front());
        if (eq_we.pop_front()) chk("R6 mask data", mem_wdata, eq_data.pop_front());
        else void'(eq_data.pop_front());
      end
      if (mem_we) begin
        mem[mem_addr[8:2]] = mem_wdata;
        mem_err = (mem_addr == err_wr);
      end else begin
        mem_rdata = mem[mem_addr[8:2]];
        mem_err = (mem_addr == err_rd);
      end
    end else mem_err = 1'b0;
    mem_ack = nack;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic expect_reload();
    if (!chan_en) return;
    if (exp_link == 0) begin exp_end++; return; end
    if (exp_link[1:0] != 0) begin exp_ealign = 1'b1; return; end
    for (int k = 0; k < 10; k++) begin
      logic [31:0] a, d;
      a = exp_link + 32'(k * 4);
      d = mem[a[8:2]];
      eq_we.push_back(1'b0); eq_addr.push_back(a); eq_data.push_back(32'd0);
      if (a == err_rd) begin exp_elink = 1'b1; return; end
      if (k != 7) begin er_sel.push_back(4'(k)); er_data.push_back(d); end
    end
    begin
      logic [31:0] b;
      b = exp_link;
      exp_link  = mem[b[8:2] + 5];
      exp_maddr = mem[b[8:2] + 8];
      exp_mdata = mem[b[8:2] + 9];
      exp_restart++;
    end
  endtask

  task automatic expect_mask();
    if (exp_maddr == 0) return;
    eq_we.push_back(1'b1); eq_addr.push_back(exp_maddr); eq_data.push_back(exp_mdata);
    if (exp_maddr == err_wr) exp_emask = 1'b1;
  endtask

  task automatic pulse_done();
    expect_reload();
    xfer_done = 1'b1; tick(); xfer_done = 1'b0;
    idle(40);
  endtask

  task automatic pulse_served();
    expect_mask();
    req_served = 1'b1; tick(); req_served = 1'b0;
    idle(10);
  endtask

  task automatic check_flags(string tag);
    chk({tag, " err_link"},  {31'd0, err_link},  {31'd0, exp_elink});
    chk({tag, " err_mask"},  {31'd0, err_mask},  {31'd0, exp_emask});
    chk({tag, " err_align"}, {31'd0, err_align}, {31'd0, exp_ealign});
    chk({tag, " restart count"}, got_restart, exp_restart);
    chk({tag, " chain_end count"}, got_end, exp_end);
    chk({tag, " pending reads"}, eq_we.size(), 0);
    chk({tag, " pending writes"}, er_sel.size(), 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    miss++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    for (int i = 0; i < 10; i++) regs[i] = '0;
    for (int i = 0; i < 128; i++) mem[i] = 32'h1000_0000 + 32'(i);
    mem[16+5] = 32'h80;  mem[16+7] = 32'hDEAD_BEEF; mem[16+8] = 32'h100; mem[16+9] = 32'hC3;
    mem[32+5] = 32'h40;  mem[32+7] = 32'hBAAD_F00D; mem[32+8] = 32'h0;   mem[32+9] = 32'h55;

    idle(3);
    chk("R11 reset outputs", {23'd0, mem_req, reg_we, restart, chain_end, err_link, err_mask, err_align, 2'b00}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    pulse_done();
    check_flags("R4 zero pointer ends chain");

    regs[5] = 32'h40; exp_link = 32'h40;
    pulse_done();
    check_flags("R1 R2 R3 first reload");

    pulse_served();
    chk("R6 mask word landed", mem[64], 32'hC3);

    pulse_done();
    pulse_done();
    check_flags("R10 circular chain");

    chan_en = 1'b0;
    pulse_done();
    check_flags("R10 disabled channel");
    chan_en = 1'b1;

    expect_mask();
    expect_reload();
    req_served = 1'b1; xfer_done = 1'b1; tick(); req_served = 1'b0; xfer_done = 1'b0;
    idle(50);
    check_flags("R7 mask before reload");

    pulse_served();
    check_flags("R6 zero mask address");

    regs[5] = 32'h42; exp_link = 32'h42;
    pulse_done();
    check_flags("R5 misaligned pointer");

    regs[5] = 32'h80; exp_link = 32'h80; err_rd = 32'h8C;
    pulse_done();
    check_flags("R8 read error");

    regs[8] = 32'h104; regs[9] = 32'h77; exp_maddr = 32'h104; exp_mdata = 32'h77; err_wr = 32'h104;
    pulse_served();
    check_flags("R9 R12 write error");

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule